// File: doc/BRIEF.md
# Taken-Branch History Ring

This block keeps a short rolling history of taken branches for a core's performance monitoring. The retire stage presents each retired branch with a taken flag, a branch type code, a problem-state flag, the branch instruction address and the branch target address. When recording is allowed, both addresses go into the next slot of a circular store, and the write offset then moves one slot forward.

Three control bits and a per-type mask decide whether a branch is recorded. The bits are a thread disable, a problem-state freeze and a freeze-sense modifier. They are loaded only on a control write. At that point they are reduced to two registered enable bits, one for problem state and one for privileged state, so each branch needs only one lookup. Software reads any entry by age through a registered read port, with index 0 being the newest record. A synchronous clear empties the store and resets the offset.

Top module: `br_hist_ring`

## Requirements
- R1: Only a branch with both `br_valid_i` and `br_taken_i` high can be recorded. A record stores the instruction address and the target address together.
- R2: Each record writes slot `wr_off_o` and advances `wr_off_o` by one, wrapping from DEPTH-1 to 0. Without a record or clear, `wr_off_o` holds.
- R3: With the disable bit written as 1, no branch is recorded. After reset the block behaves as if disable were 1 and the type mask were all zeros.
- R4: Freeze bit 0 means no freeze. Freeze 1 with modifier 0 blocks branches with `br_prob_i`=1 only. Freeze 1 with modifier 1 blocks branches with `br_prob_i`=0 only.
- R5: The branch type code is 2 bits, and a branch of type t is recorded only if bit t of the written type mask is 1.
- R6: Reset, and `clr_i` at a clock edge, set every slot to zero and `wr_off_o` to 0. `clr_i` takes precedence over a record in the same cycle.
- R7: Control fields are captured on a clock edge with `ctl_we_i`=1. They govern branches from the next cycle on, and a branch in the write cycle uses the previous settings.
- R8: `rd_ia_o`/`rd_ta_o` show, one cycle after `rd_idx_i` is applied, the record that is `rd_idx_i` places older than the newest (index 0 = newest). A slot that has not been written since the last clear reads as zero.
- R9: When a record and a read happen in the same cycle, the read returns the contents and offset from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of store and offset |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_freeze_prob_i | input | 1 | Freeze recording by privilege |
| ctl_freeze_mod_i | input | 1 | Inverts the privilege the freeze applies to |
| ctl_disable_i | input | 1 | Disable all recording |
| ctl_type_mask_i | input | 4 | Per-type record enable |
| br_valid_i | input | 1 | Branch retired strobe |
| br_taken_i | input | 1 | Branch was taken |
| br_type_i | input | 2 | Branch type code |
| br_prob_i | input | 1 | Branch retired in problem state |
| br_ia_i | input | AW | Branch instruction address |
| br_ta_i | input | AW | Branch target address |
| rd_idx_i | input | 5 | Read index by age |
| rd_ia_o | output | AW | Instruction address of read entry |
| rd_ta_o | output | AW | Target address of read entry |
| wr_off_o | output | 5 | Slot of the next record |

## Verification
The assertions check on every cycle how the offset moves: a step of one per record, no change when idle, and zero after a clear. They also check that a not-taken branch is never recorded, and that a control write setting disable, problem-state freeze or a cleared type bit blocks the matching branches in the next cycle. Only the bench's scenarios can show that address pairs land in the right slots and come back in age order after wrap-around. The bench also covers read-before-write in a shared cycle, zero reads of slots emptied by a clear, and control writes that do not apply to a branch in the same cycle.

// File: rtl/br_hist_pkg.sv
package br_hist_pkg;
  localparam int TYPE_W = 2;

  typedef enum logic [TYPE_W-1:0] {
    BT_COND   = 2'd0,
    BT_UNCOND = 2'd1,
    BT_IND    = 2'd2,
    BT_RET    = 2'd3
  } br_type_e;

  // reduced enable summary, one bit per privilege level
  typedef struct packed {
    logic rec_user;
    logic rec_priv;
  } rec_sum_t;
endpackage

// File: rtl/br_hist_gate.sv
module br_hist_gate
  import br_hist_pkg::*;
#(
  parameter int TW = TYPE_W,
  localparam int NT = 1 << TW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic          ctl_freeze_prob_i,
  input  logic          ctl_freeze_mod_i,
  input  logic          ctl_disable_i,
  input  logic [NT-1:0] ctl_type_mask_i,
  input  logic          br_valid_i,
  input  logic          br_taken_i,
  input  logic [TW-1:0] br_type_i,
  input  logic          br_prob_i,
  output logic          rec_o
);
  rec_sum_t      sum_q;
  logic [NT-1:0] mask_q;
  logic          lvl_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      mask_q <= '0;
    end else if (ctl_we_i) begin
      sum_q.rec_user <= !ctl_disable_i && !(ctl_freeze_prob_i && !ctl_freeze_mod_i);
      sum_q.rec_priv <= !ctl_disable_i && !(ctl_freeze_prob_i && ctl_freeze_mod_i);
      mask_q         <= ctl_type_mask_i;
    end
  end

  assign lvl_en = br_prob_i ? sum_q.rec_user : sum_q.rec_priv;
  assign rec_o  = br_valid_i && br_taken_i && mask_q[br_type_i] && lvl_en;

  AST_TAKEN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br_valid_i && br_taken_i) |-> !rec_o); // R1
  AST_DIS_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_disable_i |=> !rec_o); // R3
  AST_FRZ_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_freeze_prob_i && !ctl_freeze_mod_i |=> !(rec_o && br_prob_i)); // R4
  AST_FRZ_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_freeze_prob_i && ctl_freeze_mod_i |=> !(rec_o && !br_prob_i)); // R4
  AST_TYPE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && !ctl_type_mask_i[0] |=> !(rec_o && br_type_i == '0)); // R5
endmodule

// File: rtl/br_hist_store.sv
module br_hist_store #(
  parameter int AW    = 32,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rec_i,
  input  logic [AW-1:0] ia_i,
  input  logic [AW-1:0] ta_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_ia_o,
  output logic [AW-1:0] rd_ta_o,
  output logic [IW-1:0] wr_off_o
);
  logic [AW-1:0] ia_q [DEPTH];
  logic [AW-1:0] ta_q [DEPTH];
  logic [IW-1:0] off_q, off_nxt;
  logic [IW:0]   age_sum;
  logic [IW-1:0] rd_slot;

  assign off_nxt = (off_q == IW'(DEPTH-1)) ? '0 : off_q + IW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      off_q <= '0;
    else if (clr_i)   off_q <= '0;
    else if (rec_i)   off_q <= off_nxt;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ia_q[g] <= '0;
        ta_q[g] <= '0;
      end else if (clr_i) begin
        ia_q[g] <= '0;
        ta_q[g] <= '0;
      end else if (rec_i && off_q == IW'(g)) begin
        ia_q[g] <= ia_i;
        ta_q[g] <= ta_i;
      end
    end
  end

  // newest is off_q-1; age index counts backwards, modulo DEPTH
  assign age_sum = {1'b0, off_q} + (IW+1)'(DEPTH-1) - {1'b0, rd_idx_i};
  assign rd_slot = (age_sum >= (IW+1)'(DEPTH)) ? IW'(age_sum - (IW+1)'(DEPTH)) : IW'(age_sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ia_o <= '0;
      rd_ta_o <= '0;
    end else begin
      rd_ia_o <= ia_q[rd_slot];
      rd_ta_o <= ta_q[rd_slot];
    end
  end

  assign wr_off_o = off_q;

  AST_OFF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i && !clr_i && off_q != IW'(DEPTH-1) |=> off_q == $past(off_q) + IW'(1)); // R2
  AST_OFF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i && !clr_i && off_q == IW'(DEPTH-1) |=> off_q == '0); // R2
  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_i && !clr_i |=> $stable(off_q)); // R2
  AST_CLR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> off_q == '0 && ia_q[0] == '0); // R6
endmodule

// File: rtl/br_hist_ring.sv
module br_hist_ring
  import br_hist_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 32,
  parameter int TW    = TYPE_W,
  localparam int IW   = $clog2(DEPTH),
  localparam int NT   = 1 << TW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ctl_we_i,
  input  logic          ctl_freeze_prob_i,
  input  logic          ctl_freeze_mod_i,
  input  logic          ctl_disable_i,
  input  logic [NT-1:0] ctl_type_mask_i,
  input  logic          br_valid_i,
  input  logic          br_taken_i,
  input  logic [TW-1:0] br_type_i,
  input  logic          br_prob_i,
  input  logic [AW-1:0] br_ia_i,
  input  logic [AW-1:0] br_ta_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_ia_o,
  output logic [AW-1:0] rd_ta_o,
  output logic [IW-1:0] wr_off_o
);
  logic rec;

  br_hist_gate #(.TW(TW)) u_gate (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .ctl_we_i          (ctl_we_i),
    .ctl_freeze_prob_i (ctl_freeze_prob_i),
    .ctl_freeze_mod_i  (ctl_freeze_mod_i),
    .ctl_disable_i     (ctl_disable_i),
    .ctl_type_mask_i   (ctl_type_mask_i),
    .br_valid_i        (br_valid_i),
    .br_taken_i        (br_taken_i),
    .br_type_i         (br_type_i),
    .br_prob_i         (br_prob_i),
    .rec_o             (rec)
  );

  br_hist_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .rec_i    (rec),
    .ia_i     (br_ia_i),
    .ta_i     (br_ta_i),
    .rd_idx_i (rd_idx_i),
    .rd_ia_o  (rd_ia_o),
    .rd_ta_o  (rd_ta_o),
    .wr_off_o (wr_off_o)
  );
endmodule

// File: tb/br_hist_ring_tb.sv
module br_hist_ring_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D = 32;

  logic clk = 0, rst_n = 0;
  logic clr, we, fp, fm, dis, v, tk, pr;
  logic [3:0]  mask;
  logic [1:0]  ty;
  logic [31:0] ia, ta, rd_ia, rd_ta;
  logic [4:0]  idx, woff;

  int n_chk = 0, n_err = 0;

  logic [31:0] m_ia [D];
  logic [31:0] m_ta [D];
  logic [4:0]  m_off;
  logic        m_eu, m_ep;
  logic [3:0]  m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  br_hist_ring u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .ctl_we_i(we),
    .ctl_freeze_prob_i(fp), .ctl_freeze_mod_i(fm), .ctl_disable_i(dis),
    .ctl_type_mask_i(mask), .br_valid_i(v), .br_taken_i(tk), .br_type_i(ty),
    .br_prob_i(pr), .br_ia_i(ia), .br_ta_i(ta), .rd_idx_i(idx),
    .rd_ia_o(rd_ia), .rd_ta_o(rd_ta), .wr_off_o(woff)
  );

  function automatic logic would_rec();
    return v && tk && m_mask[ty] && (pr ? m_eu : m_ep);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    clr = 0; we = 0; v = 0; tk = 0; ty = 0; pr = 0; ia = 0; ta = 0;
  endtask

  // applies current inputs for one cycle, updates the model, checks outputs
  task automatic tick(string tag);
    logic [4:0]  slot;
    logic [31:0] e_ia, e_ta;
    logic        r;
    slot = m_off - 5'd1 - idx;
    e_ia = m_ia[slot];
    e_ta = m_ta[slot];
    r = would_rec();
    if (clr) begin
      for (int i = 0; i < D; i++) begin m_ia[i] = 0; m_ta[i] = 0; end
      m_off = 0;
    end else if (r) begin
      m_ia[m_off] = ia; m_ta[m_off] = ta; m_off = m_off + 5'd1;
    end
    if (we) begin
      m_eu = !dis && !(fp && !fm);
      m_ep = !dis && !(fp && fm);
      m_mask = mask;
    end
    @(posedge clk); #1;
    chk(tag, "rd_ia", rd_ia, e_ia);
    chk(tag, "rd_ta", rd_ta, e_ta);
    chk(tag, "wr_off", {27'd0, woff}, {27'd0, m_off});
    idle();
  endtask

  task automatic setctl(logic d, logic f, logic m, logic [3:0] k, string tag);
    we = 1; dis = d; fp = f; fm = m; mask = k;
    tick(tag);
  endtask

  task automatic br(logic t, logic [1:0] y, logic p, logic [31:0] a, logic [31:0] b, string tag);
    v = 1; tk = t; ty = y; pr = p; ia = a; ta = b;
    tick(tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7031));
    idle(); dis = 1; fp = 0; fm = 0; mask = 0; idx = 0;
    for (int i = 0; i < D; i++) begin m_ia[i] = 0; m_ta[i] = 0; end
    m_off = 0; m_eu = 0; m_ep = 0; m_mask = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk("R6", "reset wr_off", {27'd0, woff}, 32'd0);
    chk("R6", "reset rd_ia", rd_ia, 32'd0);

    // R3: after reset nothing records
    br(1, 0, 0, 32'h1000, 32'h2000, "R3");
    // R7: branch in the write cycle uses old (disabled) settings
    v = 1; tk = 1; ty = 0; pr = 0; ia = 32'h1100; ta = 32'h2100;
    setctl(0, 0, 0, 4'hF, "R7");
    chk("R7", "no record in write cycle", {27'd0, woff}, 32'd0);
    // R1: not-taken dropped, taken recorded
    br(0, 1, 0, 32'h1200, 32'h2200, "R1");
    br(1, 1, 0, 32'h1300, 32'h2300, "R1");
    idx = 0; tick("R8");
    chk("R8", "newest ia", rd_ia, 32'h1300);
    // R9: record and read same cycle returns old newest
    br(1, 2, 1, 32'h1400, 32'h2400, "R9");
    chk("R9", "old newest on shared cycle", rd_ia, 32'h1300);
    // R5: type filter
    setctl(0, 0, 0, 4'b0101, "R5");
    for (int t = 0; t < 4; t++) br(1, 2'(t), 0, 32'h1500 + t, 32'h2500 + t, "R5");
    // R4: freeze modes
    setctl(0, 1, 0, 4'hF, "R4");
    br(1, 0, 1, 32'h1600, 32'h2600, "R4");
    br(1, 0, 0, 32'h1601, 32'h2601, "R4");
    setctl(0, 1, 1, 4'hF, "R4");
    br(1, 0, 1, 32'h1602, 32'h2602, "R4");
    br(1, 0, 0, 32'h1603, 32'h2603, "R4");
    // R3: disable
    setctl(1, 0, 0, 4'hF, "R3");
    br(1, 1, 1, 32'h1700, 32'h2700, "R3");
    br(1, 1, 0, 32'h1701, 32'h2701, "R3");
    // R2: wrap the ring
    setctl(0, 0, 0, 4'hF, "R2");
    for (int i = 0; i < 45; i++) br(1, 2'(i), 1'(i), 32'h3000 + i, 32'h4000 + i, "R2");
    for (int i = 0; i < D; i++) begin idx = 5'(i); tick("R8"); end
    idx = 31; tick("R8");
    chk("R8", "oldest after wrap", rd_ia, 32'h3000 + 13);
    // R6: clear wins over record; then empty reads zero
    clr = 1; v = 1; tk = 1; ia = 32'h5000; ta = 32'h6000;
    tick("R6");
    idx = 0; tick("R8");
    chk("R8", "empty slot zero", rd_ta, 32'h0);
    br(1, 3, 0, 32'h5100, 32'h6100, "R6");
    idx = 1; tick("R8");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      idx = 5'($urandom);
      if ($urandom % 16 == 0) begin
        we = 1; dis = ($urandom % 4 == 0); fp = 1'($urandom); fm = 1'($urandom);
        mask = 4'($urandom);
      end
      if ($urandom % 200 == 0) clr = 1;
      v = ($urandom % 4 != 0); tk = 1'($urandom); ty = 2'($urandom);
      pr = 1'($urandom); ia = $urandom; ta = $urandom;
      tick("R1");
    end
    finish_run();
  end
endmodule